// File: doc/BRIEF.md
# Bit-Serial SIMD Memory Array

This block is a row-organised storage array in which every column has its own one-bit processing lane attached to the row register. An operand word is held vertically. Bit k of the word that belongs to lane j sits in row k, column j. Reading a row therefore gives one bit from each of many different words in a single cycle. Every lane consumes its bit in the same cycle, and no multiplexer narrows the row first.

A broadcast instruction port issues one instruction per cycle. Each instruction carries a row address, an operation code and a register select. Each lane holds three one-bit registers: an accumulator X, a carry C and an enable mask M. Arithmetic wider than one bit is performed serially. The controller issues one instruction per bit position, starting at the least significant row. A store instruction writes X back to a row, but only in the lanes whose mask is set.

A host row port reads and writes whole rows to load operands and collect results. The host port is accepted only when the array has no instruction to serve in that cycle.

Top module: `bsimd_array`

## Requirements
- R1: After reset every lane holds X=0, C=0 and M=1, and host_ack is low.
- R2: A host request is accepted when host_en=1 and the array is free. host_we=1 writes host_wdata to all columns of host_row. host_we=0 reads that row. host_ack is high in the cycle after acceptance, and in that cycle host_rdata holds the row that was read.
- R3: A host request made in a cycle where ins_valid=1 is not accepted. host_ack stays low in the following cycle and the memory is unchanged.
- R4: Bit k of the word in lane j is stored in row k, column j. A sequence of bit-serial instructions over consecutive rows therefore computes on whole vertical words.
- R5: Logic operations act on X using the addressed row bit m, with op codes AND=1 (X&m), OR=2 (X|m), XOR=3 (X^m), NOT=4 (~m) and LDX=5 (m). NOP=0 and cycles with no instruction leave X, C and M unchanged.
- R6: ADD (op 7) sets X = m^X^C and sets C to the majority of m, X and C.
- R7: An N-bit add can be built from N steps, after clearing C. Each step is LDX a_k, then ADD b_k, then STORE d_k, and the destination rows then hold (a+b) mod 2^N in every lane.
- R8: A lane with M=0 keeps its X, C and memory bits unchanged. Instructions that target M are still carried out in that lane.
- R9: STORE (op 10) writes X into the addressed row in the lanes with M=1. An instruction that reads that row in the very next cycle sees the new data.
- R10: LDR (op 6) loads m into the register picked by ins_sel, CLR (op 8) loads 0 into it and SET (op 9) loads 1 into it. The select codes are X=0, C=1 and M=2.
- R11: A host request made in the cycle after a STORE was issued is not accepted, and host_ack stays low in the cycle that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | Instruction present this cycle |
| ins_op | input | 4 | Operation code |
| ins_sel | input | 2 | Register select for LDR/CLR/SET |
| ins_row | input | AW | Row addressed by the instruction |
| host_en | input | 1 | Host row request |
| host_we | input | 1 | Host request is a write |
| host_row | input | AW | Row addressed by the host |
| host_wdata | input | LANES | Host write data |
| host_rdata | output | LANES | Registered row read data |
| host_ack | output | 1 | Host request accepted last cycle |

## Verification
Lane state can only be observed through the rows that STORE writes, so a corrupted X or C in some lane shows up as wrong columns in the next stored row. In a bit-serial add, a bad carry corrupts every higher sum row of that lane, starting one row after the fault. A mask that leaks lets writes through to columns that should have kept their earlier contents. A broken store-to-read forward shows up only when an instruction reads a row in the cycle right after that row was stored. A faulty host gate shows up as an ack, or as changed data, one cycle after a request that should have been blocked.

// File: rtl/bsimd_pkg.sv
package bsimd_pkg;
  typedef enum logic [3:0] {
    OP_NOP   = 4'd0,
    OP_AND   = 4'd1,
    OP_OR    = 4'd2,
    OP_XOR   = 4'd3,
    OP_NOT   = 4'd4,
    OP_LDX   = 4'd5,
    OP_LDR   = 4'd6,
    OP_ADD   = 4'd7,
    OP_CLR   = 4'd8,
    OP_SET   = 4'd9,
    OP_STORE = 4'd10
  } op_e;

  localparam logic [1:0] SEL_X = 2'd0;
  localparam logic [1:0] SEL_C = 2'd1;
  localparam logic [1:0] SEL_M = 2'd2;
endpackage

// File: rtl/bsimd_mem.sv
module bsimd_mem #(
  parameter int LANES = 64,
  parameter int ROWS  = 64,
  localparam int AW   = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [LANES-1:0] rdata,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [LANES-1:0] wdata,
  input  logic [LANES-1:0] wmask
);
  logic [LANES-1:0] store_q [ROWS];

  // per-column write enables keep this a bit-maskable RAM
  always_ff @(posedge clk) begin
    if (we) begin
      for (int i = 0; i < LANES; i++) begin
        if (wmask[i]) store_q[waddr][i] <= wdata[i];
      end
    end
    if (re) rdata <= store_q[raddr];
  end
endmodule

// File: rtl/bsimd_pe.sv
module bsimd_pe
  import bsimd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  op_e        op,
  input  logic [1:0] sel,
  input  logic       mbit,
  output logic       x,
  output logic       c,
  output logic       m
);
  logic x_n, c_n, m_n, val;

  always_comb begin
    x_n = x;
    c_n = c;
    m_n = m;
    val = (op == OP_LDR) ? mbit : (op == OP_SET);
    case (op)
      OP_AND: x_n = x & mbit;
      OP_OR:  x_n = x | mbit;
      OP_XOR: x_n = x ^ mbit;
      OP_NOT: x_n = ~mbit;
      OP_LDX: x_n = mbit;
      OP_ADD: begin
        x_n = mbit ^ x ^ c;
        c_n = (mbit & x) | (mbit & c) | (x & c);
      end
      OP_LDR, OP_CLR, OP_SET: begin
        if (sel == SEL_X) x_n = val;
        if (sel == SEL_C) c_n = val;
        if (sel == SEL_M) m_n = val;
      end
      default: ;
    endcase
    // an inactive lane freezes its data registers; the mask stays writable
    if (!m) begin
      x_n = x;
      c_n = c;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      x <= 1'b0;
      c <= 1'b0;
      m <= 1'b1;
    end else if (en) begin
      x <= x_n;
      c <= c_n;
      m <= m_n;
    end
  end
endmodule

// File: rtl/bsimd_array.sv
module bsimd_array
  import bsimd_pkg::*;
#(
  parameter int LANES = 64,
  parameter int ROWS  = 64,
  localparam int AW   = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ins_valid,
  input  logic [3:0]       ins_op,
  input  logic [1:0]       ins_sel,
  input  logic [AW-1:0]    ins_row,
  input  logic             host_en,
  input  logic             host_we,
  input  logic [AW-1:0]    host_row,
  input  logic [LANES-1:0] host_wdata,
  output logic [LANES-1:0] host_rdata,
  output logic             host_ack
);
  // stage 2: instruction whose row is now in the read register
  logic          st2_valid;
  op_e           st2_op;
  logic [1:0]    st2_sel;
  logic [AW-1:0] st2_row;
  logic          st2_store;
  logic          host_go;

  logic             mem_re, mem_we;
  logic [AW-1:0]    mem_raddr, mem_waddr;
  logic [LANES-1:0] mem_wdata, mem_wmask, rd_q, mem_bits;
  logic [LANES-1:0] x_vec, c_vec, m_vec;

  logic             byp_q;
  logic [LANES-1:0] byp_data, byp_mask;

  assign st2_store = st2_valid && (st2_op == OP_STORE);
  assign host_go   = host_en && !ins_valid && !st2_store;

  assign mem_re    = ins_valid || (host_go && !host_we);
  assign mem_raddr = ins_valid ? ins_row : host_row;
  assign mem_we    = st2_store || (host_go && host_we);
  assign mem_waddr = st2_store ? st2_row : host_row;
  assign mem_wdata = st2_store ? x_vec : host_wdata;
  assign mem_wmask = st2_store ? m_vec : {LANES{1'b1}};

  always_ff @(posedge clk) begin
    if (rst) begin
      st2_valid <= 1'b0;
      st2_op    <= OP_NOP;
      st2_sel   <= '0;
      st2_row   <= '0;
      host_ack  <= 1'b0;
      byp_q     <= 1'b0;
      byp_data  <= '0;
      byp_mask  <= '0;
    end else begin
      st2_valid <= ins_valid;
      st2_op    <= op_e'(ins_op);
      st2_sel   <= ins_sel;
      st2_row   <= ins_row;
      host_ack  <= host_go;
      byp_q     <= st2_store && ins_valid && (ins_row == st2_row);
      byp_data  <= x_vec;
      byp_mask  <= m_vec;
    end
  end

  bsimd_mem #(.LANES(LANES), .ROWS(ROWS)) u_mem (
    .clk   (clk),
    .re    (mem_re),
    .raddr (mem_raddr),
    .rdata (rd_q),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .wmask (mem_wmask)
  );

  // forward a store that landed after this row was read
  assign mem_bits   = byp_q ? ((byp_mask & byp_data) | (~byp_mask & rd_q)) : rd_q;
  assign host_rdata = rd_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    bsimd_pe u_pe (
      .clk  (clk),
      .rst  (rst),
      .en   (st2_valid),
      .op   (st2_op),
      .sel  (st2_sel),
      .mbit (mem_bits[g]),
      .x    (x_vec[g]),
      .c    (c_vec[g]),
      .m    (m_vec[g])
    );
  end
endmodule

// File: rtl/bsimd_chk.sv
module bsimd_chk #(
  parameter int LANES = 64
) (
  input logic             clk,
  input logic             rst,
  input logic             ins_valid,
  input logic             host_en,
  input logic             host_ack,
  input logic             st2_valid,
  input logic             st2_store,
  input logic [LANES-1:0] x_vec,
  input logic [LANES-1:0] c_vec,
  input logic [LANES-1:0] m_vec
);
  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (x_vec == '0 && c_vec == '0 && m_vec == '1 && !host_ack));

  // R2
  ack_has_request_chk: assert property (@(posedge clk) disable iff (rst)
    host_ack |-> $past(host_en));

  // R3
  host_blocked_by_ins_chk: assert property (@(posedge clk) disable iff (rst)
    ins_valid |=> !host_ack);

  // R11
  host_blocked_by_store_chk: assert property (@(posedge clk) disable iff (rst)
    st2_store |=> !host_ack);

  // R8
  masked_x_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    st2_valid |=> ((x_vec ^ $past(x_vec)) & ~$past(m_vec)) == '0);

  // R8
  masked_c_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    st2_valid |=> ((c_vec ^ $past(c_vec)) & ~$past(m_vec)) == '0);

  // R5
  idle_regs_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !st2_valid |=> ($stable(x_vec) && $stable(c_vec) && $stable(m_vec)));
endmodule

bind bsimd_array bsimd_chk #(.LANES(LANES)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ins_valid (ins_valid),
  .host_en   (host_en),
  .host_ack  (host_ack),
  .st2_valid (st2_valid),
  .st2_store (st2_store),
  .x_vec     (x_vec),
  .c_vec     (c_vec),
  .m_vec     (m_vec)
);

// File: tb/bsimd_array_tb.sv
module bsimd_array_tb;
  localparam int LANES = 64;
  localparam int ROWS  = 64;
  localparam int AW    = $clog2(ROWS);
  localparam int NB    = 8;

  localparam logic [3:0] NOP = 0, AND = 1, OR = 2, XOR = 3, NOT = 4, LDX = 5,
                         LDR = 6, ADD = 7, CLR = 8, SET = 9, STORE = 10;
  localparam logic [1:0] SX = 0, SC = 1, SM = 2;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             ins_valid = 1'b0;
  logic [3:0]       ins_op = '0;
  logic [1:0]       ins_sel = '0;
  logic [AW-1:0]    ins_row = '0;
  logic             host_en = 1'b0;
  logic             host_we = 1'b0;
  logic [AW-1:0]    host_row = '0;
  logic [LANES-1:0] host_wdata = '0;
  logic [LANES-1:0] host_rdata;
  logic             host_ack;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  bsimd_array #(.LANES(LANES), .ROWS(ROWS)) u_dut (
    .clk(clk), .rst(rst), .ins_valid(ins_valid), .ins_op(ins_op),
    .ins_sel(ins_sel), .ins_row(ins_row), .host_en(host_en),
    .host_we(host_we), .host_row(host_row), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .host_ack(host_ack)
  );

  task automatic check(input string req, input logic [LANES-1:0] got,
                       input logic [LANES-1:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  task automatic hwr(input logic [AW-1:0] row, input logic [LANES-1:0] d);
    @(negedge clk);
    host_en = 1'b1; host_we = 1'b1; host_row = row; host_wdata = d;
    @(negedge clk);
    host_en = 1'b0; host_we = 1'b0;
  endtask

  task automatic hrd(input logic [AW-1:0] row, output logic [LANES-1:0] d);
    @(negedge clk);
    host_en = 1'b1; host_we = 1'b0; host_row = row;
    @(negedge clk);
    host_en = 1'b0;
    d = host_ack ? host_rdata : 'x;
  endtask

  task automatic iss(input logic [3:0] op, input logic [1:0] sel,
                     input logic [AW-1:0] row);
    @(negedge clk);
    ins_valid = 1'b1; ins_op = op; ins_sel = sel; ins_row = row;
  endtask

  task automatic iend();
    @(negedge clk);
    ins_valid = 1'b0; ins_op = NOP;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [LANES-1:0] d;
    check("R1 ack", {63'd0, host_ack}, '0);
    iss(STORE, SX, 6'd60); iend();
    hrd(6'd60, d);
    check("R1 X=0 M=1", d, '0);
  endtask

  task automatic t_host();
    logic [LANES-1:0] v [4];
    logic [LANES-1:0] d;
    for (int i = 0; i < 4; i++) begin
      v[i] = {$urandom, $urandom};
      hwr(6'(40 + i), v[i]);
    end
    for (int i = 0; i < 4; i++) begin
      hrd(6'(40 + i), d);
      check("R2 host row", d, v[i]);
    end
  endtask

  task automatic t_logic();
    logic [LANES-1:0] a, b, d;
    a = {$urandom, $urandom}; b = {$urandom, $urandom};
    hwr(6'd24, a); hwr(6'd25, b); hwr(6'd3, '0);
    iss(LDX, SX, 6'd24); iss(AND, SX, 6'd25); iss(STORE, SX, 6'd30);
    iss(LDX, SX, 6'd24); iss(OR, SX, 6'd25);  iss(STORE, SX, 6'd31);
    iss(LDX, SX, 6'd24); iss(XOR, SX, 6'd25); iss(STORE, SX, 6'd32);
    iss(NOT, SX, 6'd24); iss(NOP, SX, 6'd0);  iss(STORE, SX, 6'd33);
    iend();
    hrd(6'd30, d); check("R5 AND", d, a & b);
    hrd(6'd31, d); check("R5 OR", d, a | b);
    hrd(6'd32, d); check("R5 XOR", d, a ^ b);
    hrd(6'd33, d); check("R5 NOT/NOP", d, ~a);
    // R10: LDR into C, then ADD on a zero row copies C into X
    iss(LDR, SC, 6'd24); iss(CLR, SX, 6'd0); iss(ADD, SX, 6'd3);
    iss(STORE, SX, 6'd34);
    iss(SET, SX, 6'd0); iss(STORE, SX, 6'd35);
    iss(CLR, SX, 6'd0); iss(STORE, SX, 6'd36);
    iend();
    hrd(6'd34, d); check("R10 LDR C", d, a);
    hrd(6'd35, d); check("R10 SET X", d, '1);
    hrd(6'd36, d); check("R10 CLR X", d, '0);
  endtask

  task automatic t_add();
    logic [NB-1:0] av [LANES];
    logic [NB-1:0] bv [LANES];
    logic [NB-1:0] sv [LANES];
    logic [LANES-1:0] ra, rb, d;
    for (int j = 0; j < LANES; j++) begin
      av[j] = NB'($urandom); bv[j] = NB'($urandom);
    end
    av[0] = '1; bv[0] = 8'd1;   // full carry ripple in lane 0
    av[1] = '1; bv[1] = '1;
    for (int k = 0; k < NB; k++) begin
      for (int j = 0; j < LANES; j++) begin
        ra[j] = av[j][k]; rb[j] = bv[j][k];
      end
      hwr(6'(k), ra); hwr(6'(8 + k), rb);
    end
    iss(CLR, SC, 6'd0);
    for (int k = 0; k < NB; k++) begin
      iss(LDX, SX, 6'(k)); iss(ADD, SX, 6'(8 + k)); iss(STORE, SX, 6'(16 + k));
    end
    iend();
    for (int k = 0; k < NB; k++) begin
      hrd(6'(16 + k), d);
      for (int j = 0; j < LANES; j++) sv[j][k] = d[j];
    end
    for (int j = 0; j < LANES; j++)
      check("R4 R6 R7 lane sum", {56'd0, sv[j]}, {56'd0, av[j] + bv[j]});
  endtask

  task automatic t_bypass();
    logic [LANES-1:0] p, q, d;
    p = {$urandom, $urandom}; q = {$urandom, $urandom};
    hwr(6'd50, p); hwr(6'd51, q);
    iss(LDX, SX, 6'd50); iss(STORE, SX, 6'd52);
    iss(LDX, SX, 6'd52); iss(XOR, SX, 6'd51); iss(STORE, SX, 6'd53);
    iend();
    hrd(6'd52, d); check("R9 store", d, p);
    hrd(6'd53, d); check("R9 read after store", d, p ^ q);
  endtask

  task automatic t_mask();
    logic [LANES-1:0] k, a, b, p, old, d;
    k = {$urandom, $urandom}; a = {$urandom, $urandom};
    b = {$urandom, $urandom}; p = {$urandom, $urandom};
    old = {$urandom, $urandom};
    hwr(6'd44, k); hwr(6'd45, a); hwr(6'd46, b); hwr(6'd47, p);
    hwr(6'd48, old); hwr(6'd3, '0);
    iss(SET, SM, 6'd0); iss(LDX, SX, 6'd47); iss(LDR, SM, 6'd44);
    iss(LDX, SX, 6'd45); iss(XOR, SX, 6'd46); iss(STORE, SX, 6'd48);
    iss(SET, SM, 6'd0); iss(STORE, SX, 6'd49);
    iend();
    hrd(6'd48, d); check("R8 masked memory", d, (k & (a ^ b)) | (~k & old));
    hrd(6'd49, d); check("R8 masked X", d, (k & (a ^ b)) | (~k & p));
    iss(CLR, SC, 6'd0); iss(LDR, SM, 6'd44); iss(SET, SC, 6'd0);
    iss(SET, SM, 6'd0); iss(CLR, SX, 6'd0); iss(ADD, SX, 6'd3);
    iss(STORE, SX, 6'd54);
    iend();
    hrd(6'd54, d); check("R8 R10 masked C", d, k);
  endtask

  task automatic t_block();
    logic [LANES-1:0] v, d;
    v = {$urandom, $urandom};
    hwr(6'd55, v); hwr(6'd57, v);
    @(negedge clk);
    ins_valid = 1'b1; ins_op = NOP; ins_row = 6'd0;
    host_en = 1'b1; host_we = 1'b1; host_row = 6'd55; host_wdata = ~v;
    @(negedge clk);
    check("R3 no ack", {63'd0, host_ack}, '0);
    ins_valid = 1'b0; host_en = 1'b0; host_we = 1'b0;
    hrd(6'd55, d); check("R3 row kept", d, v);
    @(negedge clk);
    ins_valid = 1'b1; ins_op = STORE; ins_row = 6'd56;
    @(negedge clk);
    ins_valid = 1'b0; ins_op = NOP;
    host_en = 1'b1; host_we = 1'b1; host_row = 6'd57; host_wdata = ~v;
    @(negedge clk);
    check("R11 no ack", {63'd0, host_ack}, '0);
    host_en = 1'b0; host_we = 1'b0;
    hrd(6'd57, d); check("R11 row kept", d, v);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_host();
    t_logic();
    t_add();
    t_bypass();
    t_mask();
    t_block();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1'b1;
      tests++; fails++;
      $display("FAIL watchdog got timeout exp completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule